// File: doc/BRIEF.md
# Burst Column Sequencer

This block turns the starting column of a memory read or write burst into the column address of every beat of that burst. The burst can be 4 or 8 beats long, in sequential or interleaved order. Length and order are taken from the mode-register fields when the start pulse is accepted. The block presents one beat at a time on a registered output and moves to the next beat when the consumer raises an advance input. First-beat and last-beat markers come with each beat.

In sequential order, a 4-beat burst counts up through the two lowest column bits and wraps inside its aligned group of four. An 8-beat burst does the same in the nibble that holds the start column, then repeats the count in the other nibble of the aligned group of eight. In interleaved order, the start column is XORed with the beat number over the burst's low bits. Column bits above the burst boundary never change. A new start can be issued in the same cycle as the final advance, so bursts can follow each other with no idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: The burst-length code 3'b010 selects 4 beats and 3'b011 selects 8 beats. Any other code runs a 4-beat burst, and `bl_bad_o` is high on each of its beats and low on the beats of a legal burst.
- R2: In a sequential 4-beat burst, beat i carries bits [1:0] equal to (start[1:0] + i) mod 4, and bit 2 equals start[2].
- R3: In a sequential 8-beat burst, beats 0 to 3 carry start[2] in bit 2 and beats 4 to 7 carry the inverse of start[2]. In both halves, bits [1:0] follow (start[1:0] + (i mod 4)) mod 4. For example, start 1 gives 1,2,3,0,5,6,7,4.
- R4: With `order_i` = 1 (interleaved), beat i carries start XOR i over bits [1:0] for 4 beats and over bits [2:0] for 8 beats. With `order_i` = 0 the order is sequential.
- R5: Column bits [COL_W-1:3] equal those of the start column on every beat.
- R6: `beat_valid_o` rises in the cycle after an accepted start. `first_o` is high only on beat 0 and `last_o` only on the final beat.
- R7: While `advance_i` is low, the beat address and markers hold their values.
- R8: When the last beat is advanced and `start_i` is low, `beat_valid_o` falls in the next cycle. If `start_i` is high in that cycle, the next cycle shows beat 0 of the new burst.
- R9: A start pulse during a burst is ignored unless it comes in the same cycle as the final advance.
- R10: A synchronous reset clears `beat_valid_o`, `first_o`, `last_o` and `bl_bad_o`.
- R11: The length, order and start column are sampled only when a start is accepted. Later changes to those inputs have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new burst |
| start_col_i | input | COL_W | Starting column of the burst |
| bl_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| advance_i | input | 1 | Consume the current beat |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| first_o | output | 1 | Current beat is beat 0 |
| last_o | output | 1 | Current beat is the final beat |
| bl_bad_o | output | 1 | Current burst used an illegal length code |

## Verification
The assertions check on every cycle that:
- beats hold while there is no advance;
- the markers only appear with a valid beat and never together;
- the upper column bits stay fixed inside a burst;
- the burst ends, or restarts, correctly after the last beat;
- a start during a burst does not restart it.

The exact beat orderings depend on the start column and the mode, so only the bench's sweeps can show them. The sweeps cover every low start column, both orders, both legal lengths and illegal codes. The same holds for mode inputs changed in the middle of a burst, which must not disturb it, and for a back-to-back restart.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam logic [2:0] BL_CODE_4 = 3'b010;
  localparam logic [2:0] BL_CODE_8 = 3'b011;

  typedef struct packed {
    logic len8;   // 8-beat burst
    logic ilv;    // interleaved order
    logic bad;    // illegal length code seen
  } burst_mode_t;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
(
  input  logic [2:0]  bl_code_i,
  input  logic        order_i,
  output burst_mode_t mode_o
);
  always_comb begin
    mode_o.len8 = (bl_code_i == BL_CODE_8);
    mode_o.ilv  = order_i;
    mode_o.bad  = (bl_code_i != BL_CODE_8) && (bl_code_i != BL_CODE_4);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [2:0]       idx_i,
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] col_o
);
  localparam int UP_W = COL_W - 3;

  logic [1:0] lo_seq, lo_ilv;
  logic       bit2;

  always_comb begin
    lo_seq = base_i[1:0] + idx_i[1:0];
    lo_ilv = base_i[1:0] ^ idx_i[1:0];
    // Both orders flip bit 2 in the second half of an 8-beat burst.
    bit2   = base_i[2] ^ (idx_i[2] & mode_i.len8);
    col_o  = {base_i[COL_W-1 -: UP_W], bit2, (mode_i.ilv ? lo_ilv : lo_seq)};
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             order_i,
  input  logic             advance_i,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_valid_o,
  output logic             first_o,
  output logic             last_o,
  output logic             bl_bad_o
);
  localparam int IDX_W = 3;

  burst_mode_t       dec_mode, mode_q, mode_n;
  logic [COL_W-1:0]  base_q, base_n, col_n, col_q;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              valid_q, valid_n, first_q, last_q, bad_q;
  logic              last_beat, accept;

  burst_mode_decode u_dec (
    .bl_code_i (bl_code_i),
    .order_i   (order_i),
    .mode_o    (dec_mode)
  );

  assign last_beat = valid_q && (idx_q == (mode_q.len8 ? 3'd7 : 3'd3));
  assign accept    = start_i && (!valid_q || (last_beat && advance_i));

  always_comb begin
    base_n  = base_q;
    mode_n  = mode_q;
    idx_n   = idx_q;
    valid_n = valid_q;
    if (accept) begin
      base_n  = start_col_i;
      mode_n  = dec_mode;
      idx_n   = '0;
      valid_n = 1'b1;
    end else if (valid_q && advance_i) begin
      if (last_beat) valid_n = 1'b0;
      else           idx_n   = idx_q + 3'd1;
    end
  end

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_n),
    .idx_i  (idx_n),
    .mode_i (mode_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mode_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      col_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      base_q  <= base_n;
      mode_q  <= mode_n;
      idx_q   <= idx_n;
      valid_q <= valid_n;
      col_q   <= col_n;
      first_q <= valid_n && (idx_n == 3'd0);
      last_q  <= valid_n && (idx_n == (mode_n.len8 ? 3'd7 : 3'd3));
      bad_q   <= valid_n && mode_n.bad;
    end
  end

  assign beat_col_o   = col_q;
  assign beat_valid_o = valid_q;
  assign first_o      = first_q;
  assign last_o       = last_q;
  assign bl_bad_o     = bad_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             order_i,
  input logic             advance_i,
  input logic [COL_W-1:0] beat_col_o,
  input logic             beat_valid_o,
  input logic             first_o,
  input logic             last_o,
  input logic             bl_bad_o
);
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !beat_valid_o && !first_o && !last_o && !bl_bad_o);

  p_markers_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (first_o || last_o) |-> beat_valid_o);

  p_not_both_r1: assert property (@(posedge clk) disable iff (rst)
    !(first_o && last_o));

  p_bad_valid_r1: assert property (@(posedge clk) disable iff (rst)
    bl_bad_o |-> beat_valid_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && !advance_i |=>
      beat_valid_o && $stable(beat_col_o) && $stable(first_o) && $stable(last_o));

  p_end_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && last_o && advance_i && !start_i |=> !beat_valid_o);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && last_o && advance_i && start_i |=> beat_valid_o && first_o);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && !last_o && start_i |=> !first_o);

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && !first_o |->
      beat_col_o[COL_W-1:3] == $past(beat_col_o[COL_W-1:3]));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'b010;
  logic             order = 1'b0;
  logic             advance = 1'b0;
  logic [COL_W-1:0] col;
  logic             valid, first, last, bad;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst(rst), .start_i(start), .start_col_i(start_col),
    .bl_code_i(bl_code), .order_i(order), .advance_i(advance),
    .beat_col_o(col), .beat_valid_o(valid), .first_o(first),
    .last_o(last), .bl_bad_o(bad)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int s, int i, bit l8, bit il);
    int b2 = (s >> 2) & 1;
    int lo;
    if (l8 && i >= 4) b2 = b2 ^ 1;
    if (il) lo = (s & 3) ^ (i & 3);
    else    lo = ((s & 3) + (i & 3)) % 4;
    return (s & ~7) | (b2 << 2) | lo;
  endfunction

  task automatic run_burst(input int s, input logic [2:0] code, input logic typ, input bit stall);
    bit l8 = (code == 3'b011);
    bit ill = (code != 3'b011) && (code != 3'b010);
    int n = l8 ? 8 : 4;
    string tag = typ ? "R4" : (l8 ? "R3" : "R2");
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); bl_code = code; order = typ; advance = 1'b0;
    @(negedge clk);
    // R11: scramble mode inputs while the burst runs
    start = 1'b0; start_col = ~COL_W'(s); bl_code = ~code; order = ~typ;
    for (int i = 0; i < n; i++) begin
      chk(valid == 1'b1, "R6 valid", int'(valid), 1);
      chk(int'(col) == exp_col(s, i, l8, typ), tag, int'(col), exp_col(s, i, l8, typ));
      chk((int'(col) >> 3) == (s >> 3), "R5 upper bits", int'(col) >> 3, s >> 3);
      chk(first == (i == 0) && last == (i == n - 1), "R6 markers",
          int'({first, last}), int'({(i == 0), (i == n - 1)}));
      chk(bad == ill, "R1 illegal flag", int'(bad), int'(ill));
      if (stall && i == 1) begin
        start = 1'b1;              // R9: ignored mid-burst start
        @(negedge clk);
        start = 1'b0;
        chk(int'(col) == exp_col(s, i, l8, typ) && !first && valid, "R7 R9 hold",
            int'(col), exp_col(s, i, l8, typ));
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    chk(valid == 1'b0, "R8 end of burst", int'(valid), 0);
  endtask

  initial begin
    logic [2:0] codes [4] = '{3'b010, 3'b011, 3'b000, 3'b111};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && !first && !last && !bad, "R10 reset state",
        int'({valid, first, last, bad}), 0);

    for (int k = 0; k < 16; k++)
      for (int c = 0; c < 4; c++)
        for (int t = 0; t < 2; t++)
          run_burst(k | (((k * 37) % 64) << 4), codes[c], t[0], (k % 5) == 2);

    // R3 worked example: start 1 sequential 8 gives 1,2,3,0,5,6,7,4
    run_burst(1, 3'b011, 1'b0, 1'b0);

    // R8: back-to-back restart on the final advance
    @(negedge clk);
    start = 1'b1; start_col = 10'd5; bl_code = 3'b011; order = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 7; i++) begin
      advance = 1'b1;
      @(negedge clk);
    end
    chk(last == 1'b1, "R8 last before restart", int'(last), 1);
    start = 1'b1; start_col = 10'd2; bl_code = 3'b010; order = 1'b1; advance = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    chk(valid && first && int'(col) == 2, "R8 seamless restart", int'(col), 2);
    for (int i = 1; i < 4; i++) begin
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      chk(int'(col) == (2 ^ i), "R4 restarted burst", int'(col), 2 ^ i);
    end
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk(!valid, "R8 idle after restart", int'(valid), 0);

    // R10: reset in the middle of a burst
    start = 1'b1; start_col = 10'd9; bl_code = 3'b011;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!valid && !first && !last && !bad, "R10 reset mid-burst",
        int'({valid, first, last, bad}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule